// File: doc/BRIEF.md
# Serial In-System Programming Command Slave

This block is the target side of a serial programming link. While the program-reset input is high, it samples a slow serial clock and data line in the system clock domain. It assembles bytes from them and decodes fixed four-byte instructions. It drives the read-data line back to the programmer. Through a plain memory port (address, write data, write enable, read data) it reads and writes a program-memory array. The array lives outside the block.

The instructions are: an enable handshake, a whole-array erase, byte-wide read and write, lock-mode write and read, and signature read. Two streaming page instructions move 256 consecutive bytes each. A lock-mode register sits inside the block. It steps up one level at a time, and the erase is the only way back to the unprotected level.

The programmer must keep the serial clock low for a guard interval after raising the program-reset input. Until the enable handshake has completed, every other instruction does nothing.

Top module: `isp_cmd_slave`

## Requirements
- R1: While progRst is low, miso and memWe are low, and all decode, enable and lock state returns to idle.
- R2: After progRst rises, SCK edges are ignored until SCK has been seen low for GUARD_CLKS (default 64) consecutive system clocks; a high SCK during that interval restarts the count.
- R3: MOSI is taken on each rising SCK edge, most significant bit first. MISO changes only on falling SCK edges, most significant bit first. The first bit of a loaded byte is already present before the first rising edge of that byte.
- R4: The frame 0xAC, 0x53, any, any completes the enable handshake. The slave returns 0x69 on MISO during the fourth byte, whether or not it was already enabled.
- R5: Before the handshake completes, no other instruction writes memory, changes the lock mode, or drives anything but zero bits on MISO. Dropping progRst clears the enabled state.
- R6: The frame 0x40, high, low, data writes data to address {high,low} truncated to ADDR_W bits.
- R7: The frame 0x20, high, low, any returns the byte at {high,low} on MISO during the fourth byte.
- R8: The frame 0x50, high is followed by 256 data bytes, which are written to {high,offset} for offset 0 to 255 in order. The next byte after that is decoded as a new instruction.
- R9: The frame 0x30, high is followed by 256 bytes shifted out on MISO, which are the contents of {high,offset} for offset 0 to 255 in order. Decoding of instructions resumes after the last of them.
- R10: The frame 0xAC, 0b111000ab, any, any requests lock mode ab (00 = level 1, unprotected; 11 = level 4). The request takes effect only when it is exactly one level above the current level. Otherwise it is ignored.
- R11: The frame 0x24, any, any, any returns the lock status in the fourth byte. Bit 2 is set from level 2 up, bit 3 from level 3 up, bit 4 at level 4. All other bits are 0.
- R12: The frame 0x28, any, index, any returns signature byte index[1:0] from the SIG_WORD parameter (byte k at bits 8k+7..8k). An index of 3 returns 0xFF.
- R13: The frame 0xAC, 0b100xxxxx, any, any writes 0xFF to every address, one per system clock, over 2^ADDR_W clocks, and returns the lock mode to level 1. A byte or page write that completes during this sweep is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| progRst | input | 1 | Programming-mode input, active high; low resets the block asynchronously |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |
| memAddr | output | ADDR_W | Program-memory address |
| memWdata | output | 8 | Program-memory write data |
| memWe | output | 1 | Program-memory write enable, one byte per clock |
| memRdata | input | 8 | Program-memory read data, combinational from memAddr |

## Verification
Two functions can meet in one cycle. The erase sweep holds the memory port for 2^ADDR_W clocks, and a byte write that the serial stream completes can fall inside that window. The bench provokes this by sending a byte write straight after the erase at the fastest legal SCK, so the write's last byte ends about half-way through the sweep. It then reads that address back and expects 0xFF, not the written value. Once the sweep has finished, it repeats the same write and expects it to take effect.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef struct packed {
    logic       txLoad;
    logic [7:0] txData;
  } txCtl_t;

  localparam logic [7:0] OP_PREFIX  = 8'hAC;
  localparam logic [7:0] OP_ENABLE  = 8'h53;
  localparam logic [7:0] OP_RD_BYTE = 8'h20;
  localparam logic [7:0] OP_WR_BYTE = 8'h40;
  localparam logic [7:0] OP_LOCK_RD = 8'h24;
  localparam logic [7:0] OP_SIG_RD  = 8'h28;
  localparam logic [7:0] OP_PAGE_RD = 8'h30;
  localparam logic [7:0] OP_PAGE_WR = 8'h50;
  localparam logic [7:0] ECHO_BYTE  = 8'h69;
endpackage

// File: rtl/isp_datapath.sv
module isp_datapath import isp_pkg::*; #(
  parameter int GUARD_CLKS = 64
) (
  input  logic       clk,
  input  logic       progRst,
  input  logic       sck,
  input  logic       mosi,
  input  txCtl_t     txCtl,
  output logic       byteDone,
  output logic [7:0] rxByte,
  output logic       miso
);
  localparam int GW = $clog2(GUARD_CLKS + 1);

  logic [2:0]    sckS;
  logic [1:0]    mosiS;
  logic [GW-1:0] guardCnt;
  logic          guardOk;
  logic          accRise, accFall;
  logic [2:0]    bitCnt;
  logic [7:0]    rxSh, txSh;

  assign guardOk = (guardCnt == GW'(GUARD_CLKS));
  assign accRise = guardOk && sckS[1] && !sckS[2];
  assign accFall = guardOk && !sckS[1] && sckS[2];
  assign rxByte  = rxSh;
  assign miso    = txSh[7];

  always_ff @(posedge clk or negedge progRst) begin
    if (!progRst) begin
      sckS     <= '0;
      mosiS    <= '0;
      guardCnt <= '0;
      bitCnt   <= '0;
      rxSh     <= '0;
      txSh     <= '0;
      byteDone <= 1'b0;
    end else begin
      sckS  <= {sckS[1:0], sck};
      mosiS <= {mosiS[0], mosi};
      if (!guardOk) begin
        if (sckS[1]) guardCnt <= '0;
        else         guardCnt <= guardCnt + 1'b1;
      end
      byteDone <= accRise && (bitCnt == 3'd7);
      if (accRise) begin
        rxSh   <= {rxSh[6:0], mosiS[1]};
        bitCnt <= bitCnt + 3'd1;
      end
      if (txCtl.txLoad)                  txSh <= txCtl.txData;
      else if (accFall && bitCnt != 3'd0) txSh <= {txSh[6:0], 1'b0};
    end
  end

  // R2: once the guard interval has been met it stays met until reset
  a_r2_guard_sticky: assert property (@(posedge clk) disable iff (!progRst)
    guardOk |=> guardOk);

  // R3: the outgoing shifter moves only on a falling edge or a load
  a_r3_miso_hold: assert property (@(posedge clk) disable iff (!progRst)
    (!accFall && !txCtl.txLoad) |=> $stable(txSh));
endmodule

// File: rtl/isp_control.sv
module isp_control import isp_pkg::*; #(
  parameter int          ADDR_W   = 10,
  parameter logic [23:0] SIG_WORD = 24'h7E3CA5
) (
  input  logic              clk,
  input  logic              progRst,
  input  logic              byteDone,
  input  logic [7:0]        rxByte,
  input  logic [7:0]        memRdata,
  output txCtl_t            txCtl,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe
);
  logic [1:0]        byteIdx;
  logic [7:0]        op, arg1;
  logic              enabled;
  logic [1:0]        lockMode;
  logic              pageActive, pageWr;
  logic [7:0]        pageHi, pageOff;
  logic              eraseActive;
  logic [ADDR_W-1:0] eraseAddr;
  logic [15:0]       addrReg;
  logic [7:0]        wdReg, txConst;
  logic              wrReq, txPend, txFromMem;
  logic [7:0]        lockByte;

  assign lockByte = {3'b000, lockMode == 2'd3, lockMode >= 2'd2, lockMode >= 2'd1, 2'b00};

  function automatic logic [7:0] sigByte(input logic [1:0] idx);
    if (idx == 2'd3) return 8'hFF;
    return SIG_WORD[8*idx +: 8];
  endfunction

  assign memAddr      = eraseActive ? eraseAddr : addrReg[ADDR_W-1:0];
  assign memWdata     = eraseActive ? 8'hFF : wdReg;
  assign memWe        = eraseActive || wrReq;
  assign txCtl.txLoad = txPend;
  assign txCtl.txData = txFromMem ? memRdata : txConst;

  always_ff @(posedge clk or negedge progRst) begin
    if (!progRst) begin
      byteIdx <= '0; op <= '0; arg1 <= '0; enabled <= 1'b0; lockMode <= '0;
      pageActive <= 1'b0; pageWr <= 1'b0; pageHi <= '0; pageOff <= '0;
      eraseActive <= 1'b0; eraseAddr <= '0; addrReg <= '0; wdReg <= '0;
      txConst <= '0; wrReq <= 1'b0; txPend <= 1'b0; txFromMem <= 1'b0;
    end else begin
      wrReq  <= 1'b0;
      txPend <= 1'b0;
      if (eraseActive) begin
        eraseAddr <= eraseAddr + 1'b1;
        if (eraseAddr == {ADDR_W{1'b1}}) eraseActive <= 1'b0;
      end
      if (byteDone) begin
        if (pageActive) begin
          if (pageWr && !eraseActive) begin
            addrReg <= {pageHi, pageOff}; wdReg <= rxByte; wrReq <= 1'b1;
          end
          if (!pageWr && pageOff != 8'hFF) begin
            addrReg <= {pageHi, pageOff + 8'd1}; txPend <= 1'b1; txFromMem <= 1'b1;
          end
          pageOff <= pageOff + 8'd1;
          if (pageOff == 8'hFF) pageActive <= 1'b0;
        end else begin
          case (byteIdx)
            2'd0: begin op <= rxByte; byteIdx <= 2'd1; end
            2'd1: begin
              arg1 <= rxByte;
              if (enabled && (op == OP_PAGE_RD || op == OP_PAGE_WR)) begin
                pageActive <= 1'b1; pageWr <= (op == OP_PAGE_WR);
                pageHi <= rxByte; pageOff <= '0; byteIdx <= 2'd0;
                if (op == OP_PAGE_RD) begin
                  addrReg <= {rxByte, 8'h00}; txPend <= 1'b1; txFromMem <= 1'b1;
                end
              end else byteIdx <= 2'd2;
            end
            2'd2: begin
              byteIdx <= 2'd3;
              addrReg <= {arg1, rxByte};
              if (op == OP_PREFIX && arg1 == OP_ENABLE) begin
                txPend <= 1'b1; txFromMem <= 1'b0; txConst <= ECHO_BYTE;
              end else if (enabled) begin
                case (op)
                  OP_RD_BYTE: begin txPend <= 1'b1; txFromMem <= 1'b1; end
                  OP_LOCK_RD: begin txPend <= 1'b1; txFromMem <= 1'b0; txConst <= lockByte; end
                  OP_SIG_RD:  begin txPend <= 1'b1; txFromMem <= 1'b0; txConst <= sigByte(rxByte[1:0]); end
                  default: ;
                endcase
              end
            end
            default: begin
              byteIdx <= 2'd0;
              if (op == OP_PREFIX) begin
                if (arg1 == OP_ENABLE) enabled <= 1'b1;
                else if (enabled && arg1[7:5] == 3'b100) begin
                  eraseActive <= 1'b1; eraseAddr <= '0; lockMode <= 2'd0;
                end else if (enabled && arg1[7:2] == 6'b111000 &&
                             lockMode != 2'd3 && arg1[1:0] == lockMode + 2'd1)
                  lockMode <= arg1[1:0];
              end else if (enabled && op == OP_WR_BYTE && !eraseActive) begin
                wdReg <= rxByte; wrReq <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  // R10: the lock level only steps up by one or is cleared by an erase
  a_r10_lock_step: assert property (@(posedge clk) disable iff (!progRst)
    (lockMode != $past(lockMode)) |-> (lockMode == $past(lockMode) + 2'd1 || lockMode == 2'd0));

  // R5: a serial write never reaches memory before the handshake
  a_r5_we_needs_enable: assert property (@(posedge clk) disable iff (!progRst)
    (memWe && !eraseActive) |-> enabled);

  // R8: a page stream ends only after offset 255, back at the first byte of a frame
  a_r8_page_end: assert property (@(posedge clk) disable iff (!progRst)
    $fell(pageActive) |-> (byteIdx == 2'd0 && $past(pageOff) == 8'hFF));

  // R13: the erase sweep ends only after covering the top address
  a_r13_erase_full: assert property (@(posedge clk) disable iff (!progRst)
    $fell(eraseActive) |-> $past(eraseAddr) == {ADDR_W{1'b1}});
endmodule

// File: rtl/isp_cmd_slave.sv
module isp_cmd_slave import isp_pkg::*; #(
  parameter int          ADDR_W     = 10,
  parameter int          GUARD_CLKS = 64,
  parameter logic [23:0] SIG_WORD   = 24'h7E3CA5
) (
  input  logic              clk,
  input  logic              progRst,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  input  logic [7:0]        memRdata
);
  txCtl_t     txCtl;
  logic       byteDone;
  logic [7:0] rxByte;

  isp_datapath #(.GUARD_CLKS(GUARD_CLKS)) u_dp (
    .clk(clk), .progRst(progRst), .sck(sck), .mosi(mosi), .txCtl(txCtl),
    .byteDone(byteDone), .rxByte(rxByte), .miso(miso)
  );

  isp_control #(.ADDR_W(ADDR_W), .SIG_WORD(SIG_WORD)) u_ctl (
    .clk(clk), .progRst(progRst), .byteDone(byteDone), .rxByte(rxByte),
    .memRdata(memRdata), .txCtl(txCtl), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe)
  );
endmodule

// File: tb/isp_cmd_slave_tb.sv
module isp_cmd_slave_tb;
  localparam int          AW  = 10;
  localparam logic [23:0] SIG = 24'h7E3CA5;

  logic clk = 1'b0, progRst = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0] memWdata, memRdata;
  logic [7:0] mem [2**AW];

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t expQ[$];
  logic [7:0] obsQ[$];

  always #5 clk = ~clk;

  isp_cmd_slave #(.ADDR_W(AW), .GUARD_CLKS(64), .SIG_WORD(SIG)) u_dut (
    .clk(clk), .progRst(progRst), .sck(sck), .mosi(mosi), .miso(miso),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWdata;

  function automatic logic [7:0] initVal(int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pairs each observed byte with the oldest expectation
  initial forever begin
    @(posedge clk);
    while (obsQ.size() > 0 && expQ.size() > 0) begin
      exp_t e;
      logic [7:0] o;
      e = expQ.pop_front();
      o = obsQ.pop_front();
      chk(o, e.v, e.tag);
    end
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); mosi = tx[i];
      repeat (7) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic instr(input logic [7:0] a, b, c, d, input bit doChk,
                       input logic [7:0] exp, input string tag);
    logic [7:0] r;
    xfer(a, r); xfer(b, r); xfer(c, r);
    if (doChk) expQ.push_back('{exp, tag});
    xfer(d, r);
    if (doChk) obsQ.push_back(r);
  endtask

  task automatic enterProg();
    @(negedge clk); progRst = 1'b0;
    repeat (10) @(negedge clk);
    progRst = 1'b1;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = initVal(i);
    repeat (5) @(negedge clk);
    // R1: reset state
    chk({7'd0, miso}, 8'd0, "R1 miso low in reset");
    chk({7'd0, memWe}, 8'd0, "R1 memWe low in reset");

    // R2: enable frame sent inside the guard interval is ignored
    @(negedge clk); progRst = 1'b1;
    repeat (20) @(negedge clk);
    instr(8'hAC, 8'h53, 8'h00, 8'h00, 1'b1, 8'h00, "R2 early enable ignored");
    repeat (100) @(negedge clk);
    // R5: write before enable has no effect
    instr(8'h40, 8'h00, 8'h05, 8'h12, 1'b0, 8'h00, "");
    // R4 / R3: handshake echo, MSB first
    instr(8'hAC, 8'h53, 8'h00, 8'h00, 1'b1, 8'h69, "R4 R3 enable echo");
    instr(8'h20, 8'h00, 8'h05, 8'h00, 1'b1, initVal(5), "R5 R2 pre-enable write dropped");
    // R4: repeated handshake while enabled still echoes
    instr(8'hAC, 8'h53, 8'hFF, 8'hFF, 1'b1, 8'h69, "R4 repeat echo");

    // R6 / R7: byte write and read, including the top address and truncation
    instr(8'h40, 8'h01, 8'h23, 8'hC3, 1'b0, 8'h00, "");
    instr(8'h20, 8'h01, 8'h23, 8'h00, 1'b1, 8'hC3, "R6 R7 byte at 0x123");
    instr(8'h40, 8'h03, 8'hFF, 8'h81, 1'b0, 8'h00, "");
    instr(8'h20, 8'h03, 8'hFF, 8'h00, 1'b1, 8'h81, "R6 R7 byte at top address");
    instr(8'h40, 8'hFC, 8'h40, 8'h3D, 1'b0, 8'h00, "");
    instr(8'h20, 8'h00, 8'h40, 8'h00, 1'b1, 8'h3D, "R6 upper address bits truncated");
    instr(8'h20, 8'h00, 8'h41, 8'h00, 1'b1, initVal(16'h041), "R7 untouched neighbour");

    // R8: page write to 0x200..0x2FF
    begin
      logic [7:0] r;
      xfer(8'h50, r); xfer(8'h02, r);
      for (int i = 0; i < 256; i++) xfer(8'(i * 7 + 3), r);
    end
    repeat (5) @(negedge clk);
    chk(mem[10'h200], 8'd3, "R8 page write offset 0");
    chk(mem[10'h2FF], 8'(255 * 7 + 3), "R8 page write offset 255");
    chk(mem[10'h300], initVal(10'h300), "R8 page write stays in its page");
    instr(8'h20, 8'h02, 8'h80, 8'h00, 1'b1, 8'(128 * 7 + 3), "R8 decode resumes after page");

    // R9: page read streams the same page back
    begin
      logic [7:0] r;
      xfer(8'h30, r); xfer(8'h02, r);
      for (int i = 0; i < 256; i++) begin
        expQ.push_back('{8'(i * 7 + 3), "R9 page read byte"});
        xfer(8'h00, r);
        obsQ.push_back(r);
      end
    end
    instr(8'h28, 8'h00, 8'h01, 8'h00, 1'b1, SIG[15:8], "R9 R12 decode resumes, signature 1");

    // R12: signature bytes
    instr(8'h28, 8'h00, 8'h00, 8'h00, 1'b1, SIG[7:0], "R12 signature 0");
    instr(8'h28, 8'h00, 8'h02, 8'h00, 1'b1, SIG[23:16], "R12 signature 2");
    instr(8'h28, 8'h00, 8'h03, 8'h00, 1'b1, 8'hFF, "R12 signature index 3");

    // R10 / R11: lock levels must rise in order
    instr(8'h24, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, "R11 lock read level 1");
    instr(8'hAC, 8'hE3, 8'h00, 8'h00, 1'b0, 8'h00, "");
    instr(8'h24, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, "R10 level 4 skip ignored");
    instr(8'hAC, 8'hE1, 8'h00, 8'h00, 1'b0, 8'h00, "");
    instr(8'h24, 8'h00, 8'h00, 8'h00, 1'b1, 8'h04, "R10 R11 level 2");
    instr(8'hAC, 8'hE3, 8'h00, 8'h00, 1'b0, 8'h00, "");
    instr(8'h24, 8'h00, 8'h00, 8'h00, 1'b1, 8'h04, "R10 level 4 from 2 ignored");
    instr(8'hAC, 8'hE2, 8'h00, 8'h00, 1'b0, 8'h00, "");
    instr(8'h24, 8'h00, 8'h00, 8'h00, 1'b1, 8'h0C, "R10 R11 level 3");
    instr(8'hAC, 8'hE3, 8'h00, 8'h00, 1'b0, 8'h00, "");
    instr(8'h24, 8'h00, 8'h00, 8'h00, 1'b1, 8'h1C, "R10 R11 level 4");
    instr(8'hAC, 8'hE0, 8'h00, 8'h00, 1'b0, 8'h00, "");
    instr(8'h24, 8'h00, 8'h00, 8'h00, 1'b1, 8'h1C, "R10 level 1 request ignored");

    // R13: erase, with a byte write landing inside the sweep
    instr(8'hAC, 8'h80, 8'h00, 8'h00, 1'b0, 8'h00, "");
    instr(8'h40, 8'h00, 8'h10, 8'h77, 1'b0, 8'h00, "");
    repeat (1100) @(negedge clk);
    chk(mem[10'h010], 8'hFF, "R13 write during sweep dropped");
    chk(mem[10'h000], 8'hFF, "R13 erase address 0");
    instr(8'h20, 8'h03, 8'hFF, 8'h00, 1'b1, 8'hFF, "R13 erase top address");
    instr(8'h24, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, "R13 lock back to level 1");
    instr(8'h40, 8'h00, 8'h10, 8'h77, 1'b0, 8'h00, "");
    instr(8'h20, 8'h00, 8'h10, 8'h00, 1'b1, 8'h77, "R13 write after sweep");

    // R1 / R5: reset mid-frame clears enable and frame position
    begin
      logic [7:0] r;
      xfer(8'h40, r); xfer(8'h00, r);
    end
    enterProg();
    instr(8'h20, 8'h00, 8'h10, 8'h00, 1'b1, 8'h00, "R5 R1 read ignored after reset");
    instr(8'hAC, 8'h53, 8'h00, 8'h00, 1'b1, 8'h69, "R1 frame resync after reset");
    instr(8'h20, 8'h00, 8'h10, 8'h00, 1'b1, 8'h77, "R1 memory kept across reset");

    repeat (10) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule